// File: doc/BRIEF.md
# Programmable Event Counter Unit

The block is an eight-way performance counter bank driven by a vector of single-cycle event pulses. Each counter picks one line of that vector through an 8-bit event code, and increments by one on every clock in which the selected line is high, the counter's own enable is set and the unit-wide run bit is set. Counters are 48 bits wide and wrap to zero. A wrap sets a sticky per-counter overflow flag, and a maskable level interrupt reports any unmasked flag.

Software reaches every register through a flat synchronous port. It presents a byte address, a write strobe, a width flag (32-bit or 64-bit access) and write data. Read data is combinational from the address in the same cycle. Counters occupy 64-bit slots. A 64-bit access covers the whole counter. A 32-bit access at the slot base covers bits 31:0, and a 32-bit access at base+4 covers bits 47:32.

Top module: `evcnt_unit`

## Requirements
- R1: After reset all counters are 0, the run bit and every per-counter enable are 0, every mask bit is 1, every event code is 0xFF, the status is 0 and `irq_o` is low.
- R2: Counter n is a 64-bit slot at byte address 0x1E00+8n. A 64-bit read returns the 48-bit count with bits 63:48 zero, and bits 63:48 of a 64-bit write are ignored. A 32-bit access at 0x1E00+8n covers count bits 31:0. A 32-bit access at 0x1E04+8n covers count bits 47:32, carried in data bits 15:0.
- R3: Counter n takes its code from the select word at 0x1D00+4*(n/4), bits 8*(n%4)+7 down to 8*(n%4). Code c selects event line c. A code at or above the number of event lines selects nothing.
- R4: A counter whose code is 0xFF never increments.
- R5: The run bit is bit 16 of the word at 0x0408, and only that bit is stored; other bits read 0. While run is 0, no counter changes except by a software write.
- R6: Bit n of the word at 0x1C00 enables counter n. The counter increments by exactly one in each cycle in which run, its enable and its selected event line are all 1.
- R7: Incrementing from 2^48-1 gives 0 and sets status bit n in the same edge, whatever the mask.
- R8: Bit n of the mask word at 0x0800 gates counter n's flag (0 passes, 1 blocks). `irq_o` is high exactly while some status bit is set with its mask bit 0.
- R9: Status reads at 0x0808, and writes to that address are ignored. Writing 1 to bit n at 0x080C clears status bit n; written 0 bits leave their flags as they are.
- R10: The word at 0x1CF0 reads the VERSION parameter, and writes to it are ignored.
- R11: A software write to a counter in the same cycle as its increment wins. The written value is stored and that cycle produces no overflow.
- R12: A clear and a new overflow on the same bit in the same cycle leave the flag set.
- R13: Read data reflects the presented address in the same cycle. Unmapped addresses and the clear word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 16 | Byte address of the access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_wdata | input | 64 | Write data (32-bit accesses use bits 31:0) |
| reg_rdata | output | 64 | Combinational read data for `reg_addr` |
| evt_i | input | NUM_EVT | Single-cycle event pulses, one line per event code |
| irq_o | output | 1 | Level interrupt: any unmasked overflow flag |

## Verification
The bench builds the unit with its defaults: eight counters of 48 bits, sixteen event lines and a version word of 0x0201. Sixteen lines are enough to show that codes above the line count select nothing. Eight counters put counter 5's code in the second select word, which exercises the packed field positions. The 48-bit wrap is reached by preloading a counter to within two counts of its maximum through the 64-bit write path, so overflow, the masked and unmasked interrupt, and clear-versus-overflow collisions all fall within a few hundred cycles.

// File: rtl/evcnt_pkg.sv
// Package evcnt_pkg
// Shared register addresses and helpers for the event counter unit.
// Assumes a 16-bit byte address space and 32-bit aligned register words.
package evcnt_pkg;

    localparam logic [15:0] ADDR_CTRL = 16'h0408;
    localparam logic [15:0] ADDR_MASK = 16'h0800;
    localparam logic [15:0] ADDR_STAT = 16'h0808;
    localparam logic [15:0] ADDR_CLR  = 16'h080C;
    localparam logic [15:0] ADDR_EN   = 16'h1C00;
    localparam logic [15:0] ADDR_VER  = 16'h1CF0;
    localparam logic [15:0] ADDR_SEL0 = 16'h1D00;
    localparam logic [15:0] ADDR_CNT0 = 16'h1E00;

    localparam int         RUN_BIT  = 16;
    localparam logic [7:0] EVT_NONE = 8'hFF;

    // Byte address of counter slot n (lower word)
    function automatic logic [15:0] cnt_addr(input int n);
        return ADDR_CNT0 + 16'(8 * n);
    endfunction

    // Byte address of event select word k
    function automatic logic [15:0] sel_addr(input int k);
        return ADDR_SEL0 + 16'(4 * k);
    endfunction

endpackage

// File: rtl/evcnt_ctrl_regs.sv
// Module evcnt_ctrl_regs
// Holds the run bit, per-counter enables, interrupt mask and the packed
// event select words. Write strobes arrive already decoded from the top.
// Assumes NUM_CNT is a multiple of 4 (four 8-bit codes per select word).
module evcnt_ctrl_regs
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctrl_wr_i,
    input  logic                   en_wr_i,
    input  logic                   mask_wr_i,
    input  logic [NUM_CNT/4-1:0]   sel_wr_i,
    input  logic [31:0]            wdata_i,
    output logic                   run_o,
    output logic [NUM_CNT-1:0]     en_o,
    output logic [NUM_CNT-1:0]     mask_o,
    output logic [NUM_CNT*8-1:0]   codes_o
);

    localparam int NUM_SEL = NUM_CNT / 4;

    logic               run_q;
    logic [NUM_CNT-1:0] en_q;
    logic [NUM_CNT-1:0] mask_q;

    // Global run bit: only bit 16 of the control word is kept
    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= 1'b0;
        else if (ctrl_wr_i) run_q <= wdata_i[RUN_BIT];
    end

    // Per-counter enable bits
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_wr_i) en_q <= wdata_i[NUM_CNT-1:0];
    end

    // Interrupt mask bits, all masked out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '1;
        else if (mask_wr_i) mask_q <= wdata_i[NUM_CNT-1:0];
    end

    for (genvar k = 0; k < NUM_SEL; k++) begin : g_sel
        logic [31:0] sel_q;

        // Select word k: four codes, all "no event" out of reset
        always_ff @(posedge clk) begin
            if (!rst_n)           sel_q <= '1;
            else if (sel_wr_i[k]) sel_q <= wdata_i;
        end

        assign codes_o[32*k +: 32] = sel_q;
    end

    assign run_o  = run_q;
    assign en_o   = en_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/evcnt_counter.sv
// Module evcnt_counter
// One event counter: selects an event line by code, increments when
// allowed, accepts software writes of its low and high parts, and
// flags a wrap from all-ones to zero.
// Assumes 32 < CNT_W <= 64 and NUM_EVT <= 256. A write beats an increment.
module evcnt_counter
    import evcnt_pkg::*;
#(
    parameter int CNT_W   = 48,
    parameter int NUM_EVT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 count_en_i,
    input  logic [7:0]           code_i,
    input  logic [NUM_EVT-1:0]   evt_i,
    input  logic                 wr_lo_i,
    input  logic                 wr_hi_i,
    input  logic [31:0]          lo_data_i,
    input  logic [CNT_W-33:0]    hi_data_i,
    output logic [CNT_W-1:0]     cnt_o,
    output logic                 ovf_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [255:0]     evt_wide;
    logic             hit;
    logic             wr_any;

    // Zero-extend the event vector so any 8-bit code indexes safely
    assign evt_wide = 256'(evt_i);
    assign hit      = count_en_i && (code_i != EVT_NONE) && evt_wide[code_i];
    assign wr_any   = wr_lo_i || wr_hi_i;
    assign ovf_o    = hit && !wr_any && (cnt_q == CNT_MAX);

    // Count register: software write first, then increment with wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_any) begin
            if (wr_lo_i) cnt_q[31:0]       <= lo_data_i;
            if (wr_hi_i) cnt_q[CNT_W-1:32] <= hi_data_i;
        end else if (hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/evcnt_irq.sv
// Module evcnt_irq
// Sticky overflow status with write-one-to-clear and a masked level
// interrupt. A new overflow wins over a clear of the same bit.
module evcnt_irq #(
    parameter int NUM_CNT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] ovf_i,
    input  logic               clr_wr_i,
    input  logic [NUM_CNT-1:0] clr_bits_i,
    input  logic [NUM_CNT-1:0] mask_i,
    output logic [NUM_CNT-1:0] stat_o,
    output logic               irq_o
);

    logic [NUM_CNT-1:0] stat_q;
    logic [NUM_CNT-1:0] clr_eff;

    assign clr_eff = clr_wr_i ? clr_bits_i : '0;

    // Status flags: clear requested bits, then OR in fresh overflows
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_eff) | ovf_i;
    end

    assign stat_o = stat_q;
    assign irq_o  = |(stat_q & ~mask_i);

endmodule

// File: rtl/evcnt_unit.sv
// Module evcnt_unit
// Top of the event counter unit: decodes the register port, instantiates
// the control registers, one counter per slot and the interrupt logic,
// and builds the combinational read data.
// Assumes aligned accesses; unmapped addresses read zero and drop writes.
module evcnt_unit
    import evcnt_pkg::*;
#(
    parameter int          NUM_CNT = 8,
    parameter int          CNT_W   = 48,
    parameter int          NUM_EVT = 16,
    parameter logic [31:0] VERSION = 32'h0000_0201
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        reg_addr,
    input  logic               reg_wr,
    input  logic               reg_wide,
    input  logic [63:0]        reg_wdata,
    output logic [63:0]        reg_rdata,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               irq_o
);

    localparam int HI_W    = CNT_W - 32;
    localparam int NUM_SEL = NUM_CNT / 4;

    logic                     run_w;
    logic [NUM_CNT-1:0]       en_w;
    logic [NUM_CNT-1:0]       mask_w;
    logic [NUM_CNT*8-1:0]     codes_w;
    logic [NUM_CNT-1:0]       stat_w;
    logic [NUM_CNT-1:0]       ovf_w;
    logic [NUM_SEL-1:0]       sel_wr;
    logic [HI_W-1:0]          hi_data;
    logic [CNT_W-1:0]         cnt_arr [NUM_CNT];
    logic [NUM_CNT*CNT_W-1:0] cnt_flat;
    logic [63:0]              rdata_c;
    logic                     unused_wdata;

    assign unused_wdata = ^reg_wdata[63:CNT_W];

    // High part comes from bits above 31 on a wide write, else bits 15:0 onward
    assign hi_data = reg_wide ? reg_wdata[CNT_W-1:32] : reg_wdata[HI_W-1:0];

    for (genvar k = 0; k < NUM_SEL; k++) begin : g_selwr
        assign sel_wr[k] = reg_wr && (reg_addr == sel_addr(k));
    end

    evcnt_ctrl_regs #(
        .NUM_CNT (NUM_CNT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr_i (reg_wr && (reg_addr == ADDR_CTRL)),
        .en_wr_i   (reg_wr && (reg_addr == ADDR_EN)),
        .mask_wr_i (reg_wr && (reg_addr == ADDR_MASK)),
        .sel_wr_i  (sel_wr),
        .wdata_i   (reg_wdata[31:0]),
        .run_o     (run_w),
        .en_o      (en_w),
        .mask_o    (mask_w),
        .codes_o   (codes_w)
    );

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        logic base_hit;
        logic upper_hit;

        assign base_hit  = (reg_addr == cnt_addr(n));
        assign upper_hit = (reg_addr == cnt_addr(n) + 16'd4);

        evcnt_counter #(
            .CNT_W   (CNT_W),
            .NUM_EVT (NUM_EVT)
        ) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .count_en_i (run_w && en_w[n]),
            .code_i     (codes_w[8*n +: 8]),
            .evt_i      (evt_i),
            .wr_lo_i    (reg_wr && base_hit),
            .wr_hi_i    (reg_wr && ((base_hit && reg_wide) || upper_hit)),
            .lo_data_i  (reg_wdata[31:0]),
            .hi_data_i  (hi_data),
            .cnt_o      (cnt_arr[n]),
            .ovf_o      (ovf_w[n])
        );

        assign cnt_flat[n*CNT_W +: CNT_W] = cnt_arr[n];
    end

    evcnt_irq #(
        .NUM_CNT (NUM_CNT)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_i      (ovf_w),
        .clr_wr_i   (reg_wr && (reg_addr == ADDR_CLR)),
        .clr_bits_i (reg_wdata[NUM_CNT-1:0]),
        .mask_i     (mask_w),
        .stat_o     (stat_w),
        .irq_o      (irq_o)
    );

    // Read mux: fixed words first, then select words and counter slots
    always_comb begin
        rdata_c = '0;
        case (reg_addr)
            ADDR_CTRL: rdata_c[RUN_BIT]       = run_w;
            ADDR_MASK: rdata_c[NUM_CNT-1:0]   = mask_w;
            ADDR_STAT: rdata_c[NUM_CNT-1:0]   = stat_w;
            ADDR_EN:   rdata_c[NUM_CNT-1:0]   = en_w;
            ADDR_VER:  rdata_c[31:0]          = VERSION;
            default:   rdata_c                = '0;
        endcase
        for (int k = 0; k < NUM_SEL; k++) begin
            if (reg_addr == sel_addr(k)) rdata_c[31:0] = codes_w[32*k +: 32];
        end
        for (int n = 0; n < NUM_CNT; n++) begin
            if (reg_addr == cnt_addr(n)) begin
                rdata_c = reg_wide ? 64'(cnt_arr[n]) : 64'(cnt_arr[n][31:0]);
            end else if (reg_addr == cnt_addr(n) + 16'd4) begin
                rdata_c = 64'(cnt_arr[n][CNT_W-1:32]);
            end
        end
    end

    assign reg_rdata = rdata_c;

endmodule

// File: rtl/evcnt_unit_chk.sv
// Module evcnt_unit_chk
// Temporal checks on the event counter unit, bound into every instance.
module evcnt_unit_chk
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 48
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [15:0]              reg_addr,
    input logic                     reg_wr,
    input logic                     run,
    input logic [NUM_CNT-1:0]       mask,
    input logic [NUM_CNT-1:0]       stat,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
    input logic                     irq_o
);

    logic [CNT_W-1:0] c0;
    assign c0 = cnt_flat[CNT_W-1:0];

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> ((mask == '1) && !irq_o && (stat == '0)));

    p_no_count_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reg_wr) |=> $stable(cnt_flat));

    p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((c0 == $past(c0)) || (c0 == $past(c0) + 1'b1) || (c0 == '0)));

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stat != '0));

    p_sticky_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == ADDR_CLR)) |=> ((stat & $past(stat)) == $past(stat)));

endmodule

bind evcnt_unit evcnt_unit_chk #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .run      (run_w),
    .mask     (mask_w),
    .stat     (stat_w),
    .cnt_flat (cnt_flat),
    .irq_o    (irq_o)
);

// File: tb/evcnt_unit_tb.sv
// Bench for evcnt_unit: behavioural reference model stepped every clock,
// interrupt compared every cycle, register reads compared when requested.
module evcnt_unit_tb;

    localparam logic [31:0] VER = 32'h0000_0201;
    localparam logic [63:0] MAXV = 64'h0000_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_wide = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [15:0] evt_i = '0;
    logic        irq_o;

    int tests = 0;
    int fails = 0;
    bit live  = 1'b0;

    // Reference model state
    logic [63:0] m_cnt  [8];
    logic [7:0]  m_code [8];
    logic [7:0]  m_en, m_mask, m_stat;
    bit          m_run;

    always #2 clk = ~clk;

    evcnt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wide(reg_wide), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_i(evt_i), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int n = 0; n < 8; n++) begin
            m_cnt[n]  = '0;
            m_code[n] = 8'hFF;
        end
        m_en = '0; m_mask = 8'hFF; m_stat = '0; m_run = 1'b0;
    endfunction

    function automatic logic [63:0] model_read(input logic [15:0] a, input bit wd);
        logic [63:0] r;
        r = '0;
        if (a == 16'h0408) r[16] = m_run;
        else if (a == 16'h0800) r[7:0] = m_mask;
        else if (a == 16'h0808) r[7:0] = m_stat;
        else if (a == 16'h1C00) r[7:0] = m_en;
        else if (a == 16'h1CF0) r[31:0] = VER;
        else if (a == 16'h1D00) r[31:0] = {m_code[3], m_code[2], m_code[1], m_code[0]};
        else if (a == 16'h1D04) r[31:0] = {m_code[7], m_code[6], m_code[5], m_code[4]};
        for (int n = 0; n < 8; n++) begin
            if (a == 16'h1E00 + 16'(8*n))      r = wd ? m_cnt[n] : (m_cnt[n] & 64'hFFFF_FFFF);
            else if (a == 16'h1E04 + 16'(8*n)) r = m_cnt[n] >> 32;
        end
        return r;
    endfunction

    function automatic void model_step(input logic [15:0] a, input bit w, input bit wd,
                                       input logic [63:0] d, input logic [15:0] ev);
        logic [7:0]  ovf;
        logic [63:0] hi;
        bit          wl, wh, inc;
        ovf = '0;
        for (int n = 0; n < 8; n++) begin
            wl  = w && (a == 16'h1E00 + 16'(8*n));
            wh  = w && ((wl && wd) || (a == 16'h1E04 + 16'(8*n)));
            inc = m_run && m_en[n] && (m_code[n] != 8'hFF) && (m_code[n] < 8'd16) && ev[m_code[n][3:0]];
            if (wl || wh) begin
                if (wl) m_cnt[n] = (m_cnt[n] & 64'hFFFF_0000_0000) | {32'h0, d[31:0]};
                if (wh) begin
                    hi = wd ? {48'h0, d[47:32]} : {48'h0, d[15:0]};
                    m_cnt[n] = (m_cnt[n] & 64'hFFFF_FFFF) | (hi << 32);
                end
            end else if (inc) begin
                if (m_cnt[n] == MAXV) begin
                    m_cnt[n] = '0;
                    ovf[n] = 1'b1;
                end else begin
                    m_cnt[n] = m_cnt[n] + 1;
                end
            end
        end
        m_stat = (m_stat & ~((w && a == 16'h080C) ? d[7:0] : 8'h00)) | ovf;
        if (w) begin
            if (a == 16'h0408) m_run  = d[16];
            if (a == 16'h1C00) m_en   = d[7:0];
            if (a == 16'h0800) m_mask = d[7:0];
            if (a == 16'h1D00) for (int k = 0; k < 4; k++) m_code[k]   = d[8*k +: 8];
            if (a == 16'h1D04) for (int k = 0; k < 4; k++) m_code[4+k] = d[8*k +: 8];
        end
    endfunction

    // One clock: drive at the falling edge, compare a read, step the model at the rising edge
    task automatic step(input logic [15:0] a, input bit w, input bit wd, input logic [63:0] d,
                        input logic [15:0] ev, input bit rd, input string req);
        logic [63:0] exp;
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_wide = wd; reg_wdata = d; evt_i = ev;
        #1;
        if (rd) begin
            exp = model_read(a, wd);
            check(reg_rdata == exp, req, reg_rdata, exp);
        end
        @(posedge clk);
        model_step(a, w, wd, d, ev);
    endtask

    task automatic wr32(input logic [15:0] a, input logic [31:0] d, input string req);
        step(a, 1'b1, 1'b0, {32'h0, d}, 16'h0, 1'b0, req);
    endtask

    task automatic rd(input logic [15:0] a, input bit wd, input string req);
        step(a, 1'b0, wd, 64'h0, 16'h0, 1'b1, req);
    endtask

    task automatic pulse(input logic [15:0] ev, input int count);
        for (int i = 0; i < count; i++) step(16'h0000, 1'b0, 1'b0, 64'h0, ev, 1'b0, "");
    endtask

    // Interrupt level against the model on every cycle (R8)
    always @(negedge clk) begin
        if (live) check(irq_o == (|(m_stat & ~m_mask)), "R8 irq level", 64'(irq_o), 64'(|(m_stat & ~m_mask)));
    end

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live  = 1'b1;

        // R1: reset contents
        rd(16'h0408, 1'b0, "R1 run off");
        rd(16'h1C00, 1'b0, "R1 enables clear");
        rd(16'h0800, 1'b0, "R1 mask all set");
        rd(16'h1D00, 1'b0, "R1 codes none");
        rd(16'h1D04, 1'b0, "R1 codes none hi");
        rd(16'h1E00, 1'b1, "R1 counter0 zero");
        rd(16'h0808, 1'b0, "R1 status clear");
        rd(16'h1CF0, 1'b0, "R10 version");

        // R5: counting blocked while run is 0
        wr32(16'h1C00, 32'h01, "");
        wr32(16'h1D00, 32'hFFFF_FF03, "");
        pulse(16'h0008, 5);
        rd(16'h1E00, 1'b1, "R5 no count while stopped");
        wr32(16'h0408, 32'hFFFF_FFFF, "");
        rd(16'h0408, 1'b0, "R5 only run bit stored");

        // R6: run + enable + event
        pulse(16'h0008, 3);
        pulse(16'h0004, 2);
        rd(16'h1E00, 1'b1, "R6 counter0 counted");

        // R3: counter 5 code in second word bits 15:8, code 0x20 selects nothing
        wr32(16'h1D04, 32'hFFFF_07FF, "");
        wr32(16'h1D00, 32'hFF20_FF03, "");
        wr32(16'h1C00, 32'h27, "");
        pulse(16'h0080, 4);
        pulse(16'hFFFF, 2);
        rd(16'h1E28, 1'b1, "R3 counter5 code field");
        rd(16'h1E10, 1'b1, "R3 code above line count");
        rd(16'h1E00, 1'b1, "R3 counter0 own line");
        rd(16'h1D04, 1'b0, "R3 select word readback");

        // R4: code 0xFF with enable set
        rd(16'h1E08, 1'b1, "R4 no event code");

        // R2: wide and narrow counter access
        step(16'h1E18, 1'b1, 1'b1, 64'hFFFF_1234_5678_9ABC, 16'h0, 1'b0, "");
        rd(16'h1E18, 1'b1, "R2 upper bits zero");
        rd(16'h1E1C, 1'b0, "R2 high half narrow");
        rd(16'h1E18, 1'b0, "R2 low half narrow");
        step(16'h1E1C, 1'b1, 1'b0, 64'hDEAD_BEEF_0000_ABCD, 16'h0, 1'b0, "");
        rd(16'h1E18, 1'b1, "R2 narrow high write");

        // R7/R8/R9: wrap with flag masked, then unmask and clear
        step(16'h1E00, 1'b1, 1'b1, MAXV - 1, 16'h0, 1'b0, "");
        pulse(16'h0008, 2);
        rd(16'h1E00, 1'b1, "R7 wrapped to zero");
        rd(16'h0808, 1'b0, "R7 flag set while masked");
        check(irq_o == 1'b0, "R8 masked irq low", 64'(irq_o), 64'h0);
        wr32(16'h0800, 32'hFE, "");
        #1 check(irq_o == 1'b1, "R8 unmasked irq high", 64'(irq_o), 64'h1);
        wr32(16'h080C, 32'hFE, "");
        rd(16'h0808, 1'b0, "R9 zero bits ignored");
        wr32(16'h0808, 32'h00, "");
        rd(16'h0808, 1'b0, "R9 status write ignored");
        rd(16'h080C, 1'b0, "R13 clear word reads zero");
        wr32(16'h080C, 32'h01, "");
        rd(16'h0808, 1'b0, "R9 one clears");

        // R11: write beats increment, no overflow from a written MAX
        step(16'h1E00, 1'b1, 1'b1, 64'h5, 16'h0008, 1'b0, "");
        rd(16'h1E00, 1'b1, "R11 write wins");
        step(16'h1E00, 1'b1, 1'b1, MAXV, 16'h0008, 1'b0, "");
        rd(16'h0808, 1'b0, "R11 no overflow on write");
        pulse(16'h0008, 1);
        rd(16'h0808, 1'b0, "R7 overflow after write");

        // R12: clear and overflow together
        step(16'h1E00, 1'b1, 1'b1, MAXV, 16'h0, 1'b0, "");
        step(16'h080C, 1'b1, 1'b0, 64'h01, 16'h0008, 1'b0, "");
        rd(16'h0808, 1'b0, "R12 overflow beats clear");

        // R10/R13: read-only version, unmapped address
        wr32(16'h1CF0, 32'h1234_5678, "");
        rd(16'h1CF0, 1'b0, "R10 version unchanged");
        rd(16'h0400, 1'b0, "R13 unmapped reads zero");
        step(16'h1E28, 1'b0, 1'b1, 64'h0, 16'h0080, 1'b1, "R13 same-cycle read");

        live = 1'b0;
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule